// File: doc/BRIEF.md
# March C- Memory Test Sequencer

This block is a built-in self-test sequencer for a small dynamic register array organised as rows of individually addressable bits (8 rows by 8 bits by default). It produces every address, bit select, write value and strobe needed to run the March C- algorithm over the array. It then compares each bit read back against the value it should hold. The array itself sits outside the block. The array returns the selected bit combinationally on `mem_rdata_i` while the read strobe is high. The array performs a write, or a clear of a whole row, on the clock edge that ends a strobed cycle.

A run starts with a clear phase. For eight consecutive cycles, one row per cycle, the block zeroes an entire row. Five march passes follow. Each bit gets one access cycle of two clocks: a read subcycle in which the data is checked, then a write subcycle. In the final verification pass the write subcycle carries no strobe. The first mismatch is latched together with its pass number, row, bit and expected value. Later mismatches never change the latched values. The run always completes. A run begins on its own after reset is released. A `start_i` pulse aborts the current run at any point and begins a new one from the clear phase.

Top module: `march_bist`

## Requirements
- R1: While `rst_ni` is low, `done_o`, `fail_o`, `mem_rd_o`, `mem_wr_o` and `mem_rowclr_o` are all 0.
- R2: A run opens with exactly eight consecutive cycles of `mem_rowclr_o` = 1. `mem_row_o` steps 0,1,…,7 during these cycles. No read or write strobe appears before the clear phase ends.
- R3: Each access cycle is two clocks long with the address held steady. `mem_rd_o` is high in the first clock. `mem_wr_o` is high in the second clock in passes 1 to 4 and low in pass 5. The two strobes are never high together.
- R4: The address is {row, bit}, with bit as the low part. Passes 1, 2 and 5 visit addresses 0 to 63 in ascending order. Passes 3 and 4 visit addresses 63 down to 0.
- R5: The expected read values for passes 1 to 5 are 0, 1, 0, 1 and 0. The values written in passes 1 to 4 are 1, 0, 1 and 0 (`mem_wdata_o` while `mem_wr_o` is high).
- R6: On the first read where `mem_rdata_i` differs from the expected value, `fail_o` goes to 1. At the same time `fail_elem_o` (pass number 1–5), `fail_row_o`, `fail_bit_o` and `fail_exp_o` capture that access. These outputs do not change again until the next start.
- R7: `done_o` rises exactly 648 clock edges after the edge that samples `start_i` = 1. Counted from the first edge after reset is released, it rises after 649 edges. It then stays high, with no strobes, until a start pulse arrives. A start pulse clears `done_o` and `fail_o` on the edge that samples it.
- R8: A run over a fault-free array ends with `fail_o` = 0 and every bit of the array at 0, whatever the array held before the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Restart the test from the clear phase |
| mem_row_o | output | 3 | Row select toward the array |
| mem_bit_o | output | 3 | Bit select within the row |
| mem_wdata_o | output | 1 | Value to write into the selected bit |
| mem_rd_o | output | 1 | Read strobe (first subcycle) |
| mem_wr_o | output | 1 | Single-bit write strobe (second subcycle) |
| mem_rowclr_o | output | 1 | Zero the whole selected row at the end of this cycle |
| mem_rdata_i | input | 1 | Bit read from the array |
| done_o | output | 1 | Test complete |
| fail_o | output | 1 | At least one mismatch seen in this run |
| fail_elem_o | output | 3 | Pass number of the first mismatch |
| fail_row_o | output | 3 | Row of the first mismatch |
| fail_bit_o | output | 3 | Bit of the first mismatch |
| fail_exp_o | output | 1 | Value expected at the first mismatch |

## Verification
The hardest case to reach is a mismatch that shows up only in a descending pass. Address order is otherwise hard to observe, because a stuck cell fails in the same pass whichever direction the addresses run. The bench's array model therefore injects coupling faults. In one of them, a 0-to-1 write to a higher aggressor sets a lower victim, and the first failure can then only land in pass 3 at the victim. The mirrored placement must fail in pass 1 at the victim. Stuck cells that fail again in later passes show that the first capture is kept. A restart issued after a failure and mid-run shows that the result is cleared and the sequence begins again.

// File: rtl/march_pkg.sv
package march_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CLR, ST_RUN, ST_DONE} bist_st_e;

  localparam int unsigned ELEM_W = 3;
  localparam logic [ELEM_W-1:0] ELEM_FIRST = 3'd1;
  localparam logic [ELEM_W-1:0] ELEM_LAST  = 3'd5;

  // ascending address order for passes 1, 2 and 5
  function automatic logic elem_up(input logic [ELEM_W-1:0] e);
    return !(e == 3'd3 || e == 3'd4);
  endfunction

  // value the read subcycle must return
  function automatic logic elem_exp(input logic [ELEM_W-1:0] e);
    return (e == 3'd2 || e == 3'd4);
  endfunction

  // pass has a write subcycle
  function automatic logic elem_wr(input logic [ELEM_W-1:0] e);
    return (e >= 3'd1 && e <= 3'd4);
  endfunction
endpackage

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          up_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q;
  logic          up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      up_q   <= 1'b1;
    end else if (load_i) begin
      addr_q <= up_i ? '0 : '1;
      up_q   <= up_i;
    end else if (step_i) begin
      addr_q <= up_q ? addr_q + 1'b1 : addr_q - 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign last_o = up_q ? (&addr_q) : ~(|addr_q);
endmodule

// File: rtl/march_seq.sv
module march_seq
  import march_pkg::*;
#(
  parameter int unsigned ROWS = 8,
  parameter int unsigned BITS = 8,
  localparam int unsigned RW = $clog2(ROWS),
  localparam int unsigned BW = $clog2(BITS),
  localparam int unsigned AW = RW + BW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output bist_st_e          st_o,
  output logic [ELEM_W-1:0] elem_o,
  output logic              ph_o,
  output logic [RW-1:0]     clr_row_o,
  output logic [AW-1:0]     addr_o
);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  bist_st_e          st_q;
  logic [ELEM_W-1:0] elem_q, nxt_elem;
  logic              ph_q;
  logic [RW-1:0]     clr_q;
  logic              ag_load, ag_step, ag_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      elem_q <= '0;
      ph_q   <= 1'b0;
      clr_q  <= '0;
    end else if (start_i) begin
      st_q   <= ST_CLR;
      elem_q <= '0;
      ph_q   <= 1'b0;
      clr_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_q  <= ST_CLR;
          clr_q <= '0;
        end
        ST_CLR: begin
          clr_q <= clr_q + 1'b1;
          if (clr_q == LAST_ROW) begin
            st_q   <= ST_RUN;
            elem_q <= ELEM_FIRST;
            ph_q   <= 1'b0;
          end
        end
        ST_RUN: begin
          ph_q <= ~ph_q;
          if (ph_q && ag_last) begin
            if (elem_q == ELEM_LAST) st_q <= ST_DONE;
            else                     elem_q <= elem_q + 3'd1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    nxt_elem = (st_q == ST_CLR) ? ELEM_FIRST : elem_q + 3'd1;
    ag_load  = !start_i &&
               ((st_q == ST_CLR && clr_q == LAST_ROW) ||
                (st_q == ST_RUN && ph_q && ag_last && elem_q != ELEM_LAST));
    ag_step  = !start_i && st_q == ST_RUN && ph_q && !ag_last;
  end

  march_addr_gen #(.AW(AW)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ag_load),
    .up_i   (elem_up(nxt_elem)),
    .step_i (ag_step),
    .addr_o (addr_o),
    .last_o (ag_last)
  );

  assign st_o      = st_q;
  assign elem_o    = elem_q;
  assign ph_o      = ph_q;
  assign clr_row_o = clr_q;
endmodule

// File: rtl/march_cmp.sv
module march_cmp
  import march_pkg::*;
#(
  parameter int unsigned RW = 3,
  parameter int unsigned BW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              chk_i,
  input  logic              rdata_i,
  input  logic              exp_i,
  input  logic [ELEM_W-1:0] elem_i,
  input  logic [RW-1:0]     row_i,
  input  logic [BW-1:0]     bit_i,
  output logic              fail_o,
  output logic [ELEM_W-1:0] fail_elem_o,
  output logic [RW-1:0]     fail_row_o,
  output logic [BW-1:0]     fail_bit_o,
  output logic              fail_exp_o
);
  logic miss;
  assign miss = chk_i && (rdata_i != exp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_o      <= 1'b0;
      fail_elem_o <= '0;
      fail_row_o  <= '0;
      fail_bit_o  <= '0;
      fail_exp_o  <= 1'b0;
    end else if (clear_i) begin
      fail_o      <= 1'b0;
      fail_elem_o <= '0;
      fail_row_o  <= '0;
      fail_bit_o  <= '0;
      fail_exp_o  <= 1'b0;
    end else if (miss && !fail_o) begin
      // first mismatch only
      fail_o      <= 1'b1;
      fail_elem_o <= elem_i;
      fail_row_o  <= row_i;
      fail_bit_o  <= bit_i;
      fail_exp_o  <= exp_i;
    end
  end
endmodule

// File: rtl/march_bist.sv
module march_bist
  import march_pkg::*;
#(
  parameter int unsigned ROWS = 8,
  parameter int unsigned BITS = 8,
  localparam int unsigned RW = $clog2(ROWS),
  localparam int unsigned BW = $clog2(BITS),
  localparam int unsigned AW = RW + BW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [RW-1:0]     mem_row_o,
  output logic [BW-1:0]     mem_bit_o,
  output logic              mem_wdata_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              mem_rowclr_o,
  input  logic              mem_rdata_i,
  output logic              done_o,
  output logic              fail_o,
  output logic [ELEM_W-1:0] fail_elem_o,
  output logic [RW-1:0]     fail_row_o,
  output logic [BW-1:0]     fail_bit_o,
  output logic              fail_exp_o
);
  bist_st_e          st;
  logic [ELEM_W-1:0] elem;
  logic              ph;
  logic [RW-1:0]     clr_row;
  logic [AW-1:0]     addr;
  logic              run, exp_bit;

  march_seq #(.ROWS(ROWS), .BITS(BITS)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .st_o      (st),
    .elem_o    (elem),
    .ph_o      (ph),
    .clr_row_o (clr_row),
    .addr_o    (addr)
  );

  assign run          = (st == ST_RUN);
  assign exp_bit      = elem_exp(elem);
  assign mem_rowclr_o = (st == ST_CLR);
  assign mem_row_o    = mem_rowclr_o ? clr_row : addr[AW-1:BW];
  assign mem_bit_o    = addr[BW-1:0];
  assign mem_rd_o     = run && !ph;
  assign mem_wr_o     = run && ph && elem_wr(elem);
  assign mem_wdata_o  = run && !exp_bit;
  assign done_o       = (st == ST_DONE);

  march_cmp #(.RW(RW), .BW(BW)) u_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (start_i),
    .chk_i       (mem_rd_o),
    .rdata_i     (mem_rdata_i),
    .exp_i       (exp_bit),
    .elem_i      (elem),
    .row_i       (mem_row_o),
    .bit_i       (mem_bit_o),
    .fail_o      (fail_o),
    .fail_elem_o (fail_elem_o),
    .fail_row_o  (fail_row_o),
    .fail_bit_o  (fail_bit_o),
    .fail_exp_o  (fail_exp_o)
  );
endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk #(
  parameter int unsigned ROWS = 8,
  parameter int unsigned BITS = 8,
  localparam int unsigned RW = $clog2(ROWS),
  localparam int unsigned BW = $clog2(BITS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [RW-1:0] mem_row_o,
  input logic [BW-1:0] mem_bit_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic          mem_rowclr_o,
  input logic          done_o,
  input logic          fail_o,
  input logic [2:0]    fail_elem_o,
  input logic [RW-1:0] fail_row_o,
  input logic [BW-1:0] fail_bit_o,
  input logic          fail_exp_o
);
  // R1
  always_comb
    if (!rst_ni) a_rst_quiet_r1: assert (!done_o && !fail_o && !mem_rd_o && !mem_wr_o && !mem_rowclr_o);

  p_clr_row_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rowclr_o && $past(mem_rowclr_o) && !$past(start_i)
      |-> mem_row_o == RW'($past(mem_row_o) + 1'b1));

  p_strobe_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  p_wr_after_rd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> $past(mem_rd_o) && mem_row_o == $past(mem_row_o) && mem_bit_o == $past(mem_bit_o));

  p_first_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !start_i |=> fail_o && $stable(fail_elem_o) && $stable(fail_row_o)
                           && $stable(fail_bit_o) && $stable(fail_exp_o));

  p_done_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  p_done_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_rd_o && !mem_wr_o && !mem_rowclr_o);

  p_start_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o && !fail_o && mem_rowclr_o);
endmodule

bind march_bist march_bist_chk #(.ROWS(ROWS), .BITS(BITS)) u_chk (.*);

// File: tb/march_bist_test.sv
`timescale 1ns/1ps
module march_bist_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] row, bsel, f_elem, f_row, f_bit;
  logic       wdata, rd, wr, rowclr, rdata, done, fail, f_exp;

  always #2 clk = ~clk;

  march_bist uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mem_row_o(row), .mem_bit_o(bsel), .mem_wdata_o(wdata),
    .mem_rd_o(rd), .mem_wr_o(wr), .mem_rowclr_o(rowclr),
    .mem_rdata_i(rdata), .done_o(done), .fail_o(fail),
    .fail_elem_o(f_elem), .fail_row_o(f_row), .fail_bit_o(f_bit),
    .fail_exp_o(f_exp)
  );

  // array model with fault injection: 0 none, 1 stuck-0, 2 stuck-1, 3 coupling (0->1 write at fa sets fv)
  logic [63:0] arr = 64'hA5C3_0FF0_9966_3C5A;
  logic [1:0]  kind = 2'd0;
  int          fa = 0, fv = 0;

  always_comb begin
    rdata = arr[{row, bsel}];
    if (kind == 2'd1 && int'({row, bsel}) == fa) rdata = 1'b0;
    if (kind == 2'd2 && int'({row, bsel}) == fa) rdata = 1'b1;
  end

  always @(posedge clk) begin
    if (rowclr) arr[{row, 3'd0} +: 8] <= 8'h00;
    if (wr) begin
      if (kind == 2'd3 && int'({row, bsel}) == fa && wdata && !arr[{row, bsel}]) arr[fv] <= 1'b1;
      arr[{row, bsel}] <= wdata;
    end
  end

  // access-order monitor
  int k = 0, clr_k = 0, e2 = 0, e3 = 0, e4 = 0, e5 = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rowclr) begin
        if (k != 0 || int'(row) != clr_k || rd || wr) e2++;
        clr_k++;
      end
      if (rd || wr) begin
        int el, j, ph, xa;
        if (k < 512) begin el = k / 128 + 1; j = (k % 128) / 2; ph = k % 2; end
        else begin el = 5; j = k - 512; ph = 0; end
        xa = (el == 3 || el == 4) ? 63 - j : j;
        if (clr_k != 8) e2++;
        if (rd != (ph == 0) || wr != (ph == 1 && el <= 4)) e3++;
        if (int'({row, bsel}) != xa) e4++;
        if (wr && wdata != (el == 1 || el == 3)) e5++;
        k++;
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic mon_zero();
    k = 0; clr_k = 0; e2 = 0; e3 = 0; e4 = 0; e5 = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); #1;
    start = 1'b1;
    mon_zero();
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done(output int cnt);
    cnt = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      cnt++;
      if (done) break;
    end
  endtask

  task automatic seq_checks();
    chk(clr_k == 8 && e2 == 0, "R2 clear phase rows", clr_k, 8);
    chk(e3 == 0, "R3 subcycle strobes", e3, 0);
    chk(e4 == 0 && k == 576, "R4 address order", k, 576);
    chk(e5 == 0, "R5 write values", e5, 0);
  endtask

  typedef struct packed {
    logic [1:0] kind;
    logic [5:0] fa;
    logic [5:0] fv;
    logic       pre1;
    logic       xfail;
    logic [2:0] xelem;
    logic [5:0] xaddr;
    logic       xval;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 6'd0,  6'd0,  1'b0, 1'b0, 3'd0, 6'd0,  1'b0},  // good, zero preload
    '{2'd0, 6'd0,  6'd0,  1'b1, 1'b0, 3'd0, 6'd0,  1'b0},  // good, ones preload
    '{2'd1, 6'd0,  6'd0,  1'b0, 1'b1, 3'd2, 6'd0,  1'b1},  // stuck-0 at first cell
    '{2'd2, 6'd63, 6'd0,  1'b0, 1'b1, 3'd1, 6'd63, 1'b0},  // stuck-1 at last cell
    '{2'd1, 6'd37, 6'd0,  1'b1, 1'b1, 3'd2, 6'd37, 1'b1},  // stuck-0 mid
    '{2'd2, 6'd9,  6'd0,  1'b0, 1'b1, 3'd1, 6'd9,  1'b0},  // stuck-1, fails again later
    '{2'd3, 6'd40, 6'd12, 1'b0, 1'b1, 3'd3, 6'd12, 1'b0},  // victim below aggressor: descending pass
    '{2'd3, 6'd12, 6'd40, 1'b0, 1'b1, 3'd1, 6'd40, 1'b0}   // victim above aggressor
  };

  initial begin
    int cnt;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!done && !fail, "R1 flags in reset", {done, fail}, 0);
    chk(!rd && !wr && !rowclr, "R1 strobes in reset", {rd, wr, rowclr}, 0);

    // autonomous run after reset release
    #1; rst_n = 1'b1;
    mon_zero();
    wait_done(cnt);
    chk(cnt == 649, "R7 cycles from reset", cnt, 649);
    chk(!fail, "R8 good array after reset", fail, 0);
    chk(arr == 64'd0, "R8 array zero after reset run", int'(arr[31:0] | arr[63:32]), 0);
    seq_checks();

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      @(negedge clk); #1;
      kind = v.kind; fa = int'(v.fa); fv = int'(v.fv);
      arr = v.pre1 ? '1 : '0;
      pulse_start();
      chk(!done, "R7 done low after start", done, 0);
      wait_done(cnt);
      chk(cnt == 648, "R7 cycles from start", cnt, 648);
      chk(fail == v.xfail, v.xfail ? "R6 mismatch flagged" : "R8 good array passes", fail, v.xfail);
      if (v.xfail) begin
        chk(f_elem == v.xelem, "R6 pass number", f_elem, v.xelem);
        chk({f_row, f_bit} == v.xaddr, "R6 row and bit", {f_row, f_bit}, v.xaddr);
        chk(f_exp == v.xval, "R6 expected value", f_exp, v.xval);
      end else begin
        chk(arr == 64'd0, "R8 array zero at end", int'(arr[31:0] | arr[63:32]), 0);
      end
      seq_checks();
    end

    // done and first capture held
    repeat (20) @(negedge clk);
    chk(done && fail, "R7 done held", {done, fail}, 3);
    chk(f_elem == 3'd1 && {f_row, f_bit} == 6'd40, "R6 capture held", {f_elem, f_row, f_bit}, {3'd1, 6'd40});

    // restart mid-run after a mismatch
    @(negedge clk); #1;
    kind = 2'd2; fa = 9;
    pulse_start();
    repeat (300) @(negedge clk);
    chk(fail && !done, "R6 early mismatch mid-run", {fail, done}, 2);
    pulse_start();
    chk(!fail && !done, "R7 restart clears flags", {fail, done}, 0);
    chk(rowclr && row == 3'd0, "R2 restart begins clear", {rowclr, row}, 8);
    wait_done(cnt);
    chk(cnt == 648, "R7 cycles after restart", cnt, 648);
    chk(fail && f_elem == 3'd1 && {f_row, f_bit} == 6'd9, "R6 capture after restart", {f_elem, f_row, f_bit}, {3'd1, 6'd9});
    seq_checks();

    // restart mid-run onto a good array
    @(negedge clk); #1;
    kind = 2'd0;
    pulse_start();
    repeat (450) @(negedge clk);
    pulse_start();
    wait_done(cnt);
    chk(cnt == 648 && !fail, "R8 good after interrupted run", {fail, 12'(cnt)}, 648);
    chk(arr == 64'd0, "R8 array zero after restart", int'(arr[31:0] | arr[63:32]), 0);
    seq_checks();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule